// File: doc/BRIEF.md
# Time Slot Interchange Switch

This block switches the circuits carried on one time-division trunk. Each frame holds N sample slots, and a sample's slot number is the only thing that tells the block where it belongs. No header travels with the sample. The block writes incoming samples into a frame store in the order they arrive. Once the frame is complete, it reads them back in an order set by a mapping table, so each sample leaves in the slot of its destination circuit.

The block has two frame stores that trade roles at each frame boundary. One frame is written while the previous frame is read, so every sample is delayed by one frame. Entry `s` of the mapping table names the input slot that is sent during output slot `s`. Several entries may name the same input slot, which gives multicast. A host loads a shadow copy of the table one entry at a time, and that copy becomes live at the next frame start. For example, with 0-based slots and sessions 0→2, 1→0, 2→3 and 3→1, the table holds {1, 3, 0, 2}.

Output slots are produced in step with the input. Each accepted input sample of frame k+1 releases, one clock later, the output sample for the same slot number from frame k.

Top module: `tsi_switch`

## Requirements
- R1: After reset, `outValid` and `outFrameStart` are low, and both the live and shadow tables hold the identity mapping (entry s = s).
- R2: A sample accepted with `inFrameStart` high is slot 0. The following accepted samples are slots 1, 2, and so on up to N-1. Samples presented before the first frame start are ignored.
- R3: Samples presented after slot N-1 and before the next frame start are dropped. They are not stored and they produce no output.
- R4: When the input sample for slot s of frame k+1 is accepted, then one clock later `outValid` is high and `outSample` equals the sample that arrived in input slot `table[s]` of frame k.
- R5: `outFrameStart` is high exactly with the output of slot 0, and never without `outValid`.
- R6: No output is produced until a second frame start has been accepted.
- R7: Several table entries may name the same input slot. Each of those output slots then carries a copy of that one stored sample.
- R8: A table write (`cfgWrEn`, `cfgAddr` = output slot, `cfgData` = input slot) goes to the shadow table. The shadow table is copied into the live table when the next frame start is accepted. A write made in the same cycle as a frame start only takes effect at the frame start after that one.
- R9: A table write whose address or data is N or larger is ignored.
- R10: A cycle with `inValid` low produces no output and does not advance the slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An input sample is present this cycle |
| inFrameStart | input | 1 | The present sample is slot 0 of a new frame |
| inSample | input | W | Input sample |
| cfgWrEn | input | 1 | Write strobe for a shadow table entry |
| cfgAddr | input | clog2(N) | Output slot whose entry is written |
| cfgData | input | clog2(N) | Input slot to be read during that output slot |
| outValid | output | 1 | An output sample is present |
| outFrameStart | output | 1 | The output sample is slot 0 |
| outSample | output | W | Output sample |

## Verification
The assertions assume that `inFrameStart` is only meaningful together with `inValid`. They also assume that every frame boundary the line delivers is a real one, so a count of frame starts since reset tells whether output is allowed. The stimulus always raises `inFrameStart` together with `inValid`. It sends full frames, sometimes with idle gaps or extra trailing samples. It makes every table write either between samples or in the same cycle as a frame start, so that each case in R8 is covered.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // Strobes from the control to the datapath, all valid in the current cycle.
  typedef struct packed {
    logic wrEn;      // store the present sample
    logic wrBank;    // frame store being written
    logic rdEn;      // emit an output slot
    logic newFrame;  // an accepted frame start: swap the tables
    logic outStart;  // the slot being emitted is slot 0
  } tsiStrobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int N = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inValid,
  input  logic                    inFrameStart,
  output tsiStrobe_t              strobe,
  output logic [$clog2(N)-1:0]    slotIdx
);
  localparam int SW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] nextSlot;
  logic          bankSel;
  logic          started;
  logic          primed;
  logic          accept;

  assign accept  = inValid && (inFrameStart || (started && (nextSlot < CW'(N))));
  assign slotIdx = inFrameStart ? '0 : nextSlot[SW-1:0];

  always_comb begin
    strobe.wrEn     = accept;
    strobe.wrBank   = inFrameStart ? ~bankSel : bankSel;
    strobe.rdEn     = accept && (primed || (inFrameStart && started));
    strobe.newFrame = accept && inFrameStart;
    strobe.outStart = inFrameStart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nextSlot <= '0;
      bankSel  <= 1'b0;
      started  <= 1'b0;
      primed   <= 1'b0;
    end else begin
      if (accept) nextSlot <= CW'(slotIdx) + CW'(1);
      if (strobe.newFrame) begin
        bankSel <= ~bankSel;
        started <= 1'b1;
        if (started) primed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int N = 24,
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  tsiStrobe_t            strobe,
  input  logic [$clog2(N)-1:0]  slotIdx,
  input  logic [W-1:0]          inSample,
  input  logic                  cfgWrEn,
  input  logic [$clog2(N)-1:0]  cfgAddr,
  input  logic [$clog2(N)-1:0]  cfgData,
  output logic                  outValid,
  output logic                  outFrameStart,
  output logic [W-1:0]          outSample
);
  localparam int SW = $clog2(N);

  logic [W-1:0]  frameMem  [2][N];
  logic [SW-1:0] shadowMap [N];
  logic [SW-1:0] activeMap [N];
  logic [SW-1:0] srcSlot;
  logic          cfgOk;

  assign cfgOk = cfgWrEn && ({1'b0, cfgAddr} < (SW+1)'(N))
                         && ({1'b0, cfgData} < (SW+1)'(N));

  // The table that goes live at a frame start already serves that slot 0.
  assign srcSlot = strobe.newFrame ? shadowMap[slotIdx] : activeMap[slotIdx];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) frameMem[strobe.wrBank][slotIdx] <= inSample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        shadowMap[i] <= SW'(i);
        activeMap[i] <= SW'(i);
      end
    end else begin
      if (strobe.newFrame) activeMap <= shadowMap;
      if (cfgOk) shadowMap[cfgAddr] <= cfgData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid      <= 1'b0;
      outFrameStart <= 1'b0;
      outSample     <= '0;
    end else begin
      outValid      <= strobe.rdEn;
      outFrameStart <= strobe.rdEn && strobe.outStart;
      if (strobe.rdEn) outSample <= frameMem[~strobe.wrBank][srcSlot];
    end
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int N = 24,
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  input  logic                  inFrameStart,
  input  logic [W-1:0]          inSample,
  input  logic                  cfgWrEn,
  input  logic [$clog2(N)-1:0]  cfgAddr,
  input  logic [$clog2(N)-1:0]  cfgData,
  output logic                  outValid,
  output logic                  outFrameStart,
  output logic [W-1:0]          outSample
);
  tsiStrobe_t            strobe;
  logic [$clog2(N)-1:0]  slotIdx;

  tsi_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inFrameStart(inFrameStart),
    .strobe(strobe), .slotIdx(slotIdx)
  );

  tsi_datapath #(.N(N), .W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .slotIdx(slotIdx),
    .inSample(inSample), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outValid(outValid), .outFrameStart(outFrameStart), .outSample(outSample)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk (
  input logic clk,
  input logic rst_n,
  input logic inValid,
  input logic inFrameStart,
  input logic outValid,
  input logic outFrameStart
);
  logic [1:0] startsSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) startsSeen <= '0;
    else if (inValid && inFrameStart && startsSeen != 2'd2) startsSeen <= startsSeen + 2'd1;
  end

  assert_out_follows_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  assert_idle_no_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inValid && !inFrameStart) |=> !outValid);

  assert_start_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    outFrameStart |-> outValid);

  assert_start_from_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(inValid && inFrameStart) |=> !outFrameStart);

  assert_no_output_unprimed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (startsSeen == 2'd2));
endmodule

bind tsi_switch tsi_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inFrameStart(inFrameStart),
  .outValid(outValid), .outFrameStart(outFrameStart)
);

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
  localparam int N  = 24;
  localparam int W  = 8;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic          inFrameStart = 1'b0;
  logic [W-1:0]  inSample = '0;
  logic          cfgWrEn = 1'b0;
  logic [SW-1:0] cfgAddr = '0;
  logic [SW-1:0] cfgData = '0;
  logic          outValid;
  logic          outFrameStart;
  logic [W-1:0]  outSample;

  always #4 clk = ~clk;

  tsi_switch #(.N(N), .W(W)) u_tsi_switch (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inFrameStart(inFrameStart),
    .inSample(inSample), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outValid(outValid), .outFrameStart(outFrameStart), .outSample(outSample)
  );

  typedef struct { logic [W-1:0] d; logic fs; } expItem_t;
  expItem_t expQ[$];

  int    testsRun = 0;
  int    testsFailed = 0;
  bit    finished = 0;
  string phase = "R1 reset";

  logic [W-1:0] prevFrame [N];
  logic [W-1:0] curFrame  [N];
  int shadowM [N];
  int activeM [N];
  int framesStarted = 0;
  int slotPtr = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s [%s]: actual %0d expected %0d", req, phase, act, expv);
    end
  endtask

  // One bench cycle: optional sample, optional table write, modelled together.
  task automatic drive(input bit v, input bit fs, input logic [W-1:0] d,
                       input bit cw, input int ca, input int cd);
    int slot;
    bit acc;
    @(negedge clk);
    inValid = v; inFrameStart = v && fs; inSample = d;
    cfgWrEn = cw; cfgAddr = SW'(ca); cfgData = SW'(cd);
    if (v) begin
      slot = fs ? 0 : slotPtr;
      acc  = fs || (framesStarted > 0 && slotPtr < N);
      if (acc && fs) begin
        for (int i = 0; i < N; i++) begin
          prevFrame[i] = curFrame[i];
          activeM[i] = shadowM[i];
        end
        framesStarted++;
      end
      if (acc) begin
        curFrame[slot] = d;
        if (framesStarted >= 2) begin
          expItem_t e;
          e.d = prevFrame[activeM[slot]];
          e.fs = (slot == 0);
          expQ.push_back(e);
        end
        slotPtr = slot + 1;
      end
    end
    if (cw && ca < N && cd < N) shadowM[ca] = cd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, '0, 0, 0, 0);
  endtask

  task automatic cfgWrite(input int a, input int d);
    drive(0, 0, '0, 1, a, d);
  endtask

  task automatic sendFrame(input int extra, input bit gaps);
    for (int s = 0; s < N + extra; s++) begin
      drive(1, s == 0, W'($urandom), 0, 0, 0);
      if (gaps && (s % 5 == 2)) idle(2);
    end
  endtask

  // Monitor: pop one expectation per output sample.
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (expQ.size() == 0) begin
        check(0, "R6/R3 unexpected output", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(outSample == e.d, "R4 data", int'(outSample), int'(e.d));
        check(outFrameStart == e.fs, "R5 frame start", int'(outFrameStart), int'(e.fs));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      shadowM[i] = i; activeM[i] = i; prevFrame[i] = '0; curFrame[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(outFrameStart == 1'b0, "R1 outFrameStart after reset", int'(outFrameStart), 0);
    rst_n = 1'b1;

    phase = "R2 samples before first frame start";
    for (int i = 0; i < 3; i++) drive(1, 0, 8'hA5, 0, 0, 0);
    idle(2);
    check(outValid == 1'b0, "R2 no output from unframed samples", int'(outValid), 0);

    phase = "R6 first frame, identity table R1";
    sendFrame(0, 0);
    check(outValid == 1'b0, "R6 silent during first frame", int'(outValid), 0);
    sendFrame(0, 0);

    phase = "R10 idle gaps inside frames";
    sendFrame(0, 1);
    idle(3);
    check(outValid == 1'b0, "R10 idle cycles emit nothing", int'(outValid), 0);

    phase = "R8 permutation loaded mid-frame";
    drive(1, 1, W'($urandom), 0, 0, 0);
    for (int s = 1; s < N; s++) begin
      drive(1, 0, W'($urandom), 0, 0, 0);
      if (s < N / 2) cfgWrite(s, (s * 5 + 3) % N);
    end
    for (int s = N / 2; s < N; s++) cfgWrite(s, (s * 7 + 1) % N);
    cfgWrite(0, 3);
    sendFrame(0, 0);
    sendFrame(0, 0);

    phase = "R8 table write on a frame start";
    drive(1, 1, W'($urandom), 1, 2, 9);
    for (int s = 1; s < N; s++) drive(1, 0, W'($urandom), 0, 0, 0);
    sendFrame(0, 0);

    phase = "R3 extra samples after last slot";
    sendFrame(3, 0);
    sendFrame(2, 1);

    phase = "R7 multicast of one input slot";
    for (int s = 0; s < N; s++) cfgWrite(s, (s < N / 2) ? 5 : N - 1);
    sendFrame(0, 0);
    sendFrame(0, 0);

    phase = "R9 out-of-range table writes";
    drive(0, 0, '0, 1, N, 1);
    drive(0, 0, '0, 1, 1, N);
    drive(0, 0, '0, 1, N + 3, N + 4);
    sendFrame(0, 0);
    sendFrame(0, 0);

    phase = "R4 flush";
    sendFrame(0, 0);
    idle(4);
    check(expQ.size() == 0, "R4 all expected outputs seen", expQ.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule